// File: doc/BRIEF.md
# Bitmap-Free Spare Line Allocator

This block decides how a memory with a small set of spare rows and spare columns should be repaired. No fail bitmap is kept. During the test a BIST engine sends the address of each failing cell, one at a time. The block keeps a short list of pivot entries: the number of spare rows plus the number of spare columns. Each entry holds one row address, one column address, an essential-row flag and an essential-column flag. A failure that shares a line with a stored pivot does not take a new entry. It marks the shared line as essential, because that line now holds at least two failures and must be replaced as a whole.

When the engine signals end of test, the block walks the entries twice, one entry per clock. The first pass gives spare rows to the essential rows and spare columns to the essential columns. The second pass covers the pivots that have no flag. It uses spare rows first and then spare columns. The result is a list of replacement row and column addresses with a valid bit for each slot, a done flag and a repairable flag. A clear pulse starts a new session.

Top module: `esp_repair_analyzer`

## Requirements
- R1: After reset, and in the cycle after a clear pulse, no pivots are held, done and repairable are 0, and every slot valid bit is 0.
- R2: A failure whose row and column both differ from every stored pivot takes the next free pivot entry, with both flags clear.
- R3: A failure whose row equals a stored row pivot marks that entry as an essential row and takes no new entry. The row then gets a spare row.
- R4: A failure whose column equals a stored column pivot marks that entry as an essential column and takes no new entry. The column then gets a spare column.
- R5: A failure whose row matches one pivot and whose column matches another only sets both flags and stores nothing.
- R6: A repeated report of a failing address that is already stored as a pivot changes nothing.
- R7: If a failure needs a new entry when all pivot entries are in use, the result is done with repairable 0.
- R8: If the essential rows need more than the spare rows, or the essential columns need more than the spare columns, the result is done with repairable 0.
- R9: Spare slots fill from index 0 upward. Bit group s of a spare output is slot s and valid bit s marks it used. In the first pass the essential lines are taken in entry order. In the second pass the unflagged pivots are taken in entry order, rows first and then columns. Unused slots read address 0.
- R10: Once done is 1, the done, repairable, spare address and valid outputs stay constant and failure reports are ignored, until the next clear.
- R11: Repairable is never 1 while done is 0. A session with no failures finishes repairable with no slot used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Start a new session (one-cycle pulse) |
| flt_vld_i | input | 1 | A failing cell address is presented |
| flt_row_i | input | ROW_W | Row address of the failing cell |
| flt_col_i | input | COL_W | Column address of the failing cell |
| test_end_i | input | 1 | End of test, start allocation |
| spr_row_o | output | N_SR*ROW_W | Row addresses given to spare rows, slot s at bits s*ROW_W |
| spr_row_use_o | output | N_SR | Valid bit per spare-row slot |
| spr_col_o | output | N_SC*COL_W | Column addresses given to spare columns, slot s at bits s*COL_W |
| spr_col_use_o | output | N_SC | Valid bit per spare-column slot |
| done_o | output | 1 | Allocation finished |
| repairable_o | output | 1 | Repair fits the spares (valid with done) |

## Verification
Fully orthogonal failures, one with a repeated address, show that new pivots are taken in arrival order and that the rows-first order for unflagged pivots holds. A mixed sequence with a shared row and a shared column shows that essential lines are served before orthogonal ones. A failure that hits a row pivot and a column pivot at once is followed by enough failures to fill every entry. If that failure had taken an entry, the session would overflow, so this run separates flag-only handling from storing. Five orthogonal failures, three essential rows and three essential columns each tell the three ways a session can end irreparable apart from the repairable cases. Failures sent after done and an empty session cover freezing and the trivial result.

// File: rtl/esp_pkg.sv
// Shared definitions for the spare-pivot redundancy analyzer.
package esp_pkg;
    // Allocation phases: collect failures, serve essential lines, cover orthogonal pivots, finished.
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_ESS     = 2'd1,
        ST_ORTH    = 2'd2,
        ST_FIN     = 2'd3
    } esp_state_e;
endpackage

// File: rtl/esp_pivot_file.sv
// Pivot register file. Holds up to NENT pairs of row and column pivots, each with an
// essential-row and an essential-column flag. Each failure is compared with all stored
// pivots. Assumes at most one failure per cycle, presented only while accept is 1.
// Row pivots stay unique, and so do column pivots, because an entry is written only
// when nothing matches.
module esp_pivot_file #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int NENT  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        accept,
    input  logic                        flt_vld,
    input  logic [ROW_W-1:0]            flt_row,
    input  logic [COL_W-1:0]            flt_col,
    output logic [NENT-1:0][ROW_W-1:0]  prow,
    output logic [NENT-1:0][COL_W-1:0]  pcol,
    output logic [NENT-1:0]             vld,
    output logic [NENT-1:0]             esr,
    output logic [NENT-1:0]             esc,
    output logic [NENT-1:0]             rhit,
    output logic [NENT-1:0]             chit,
    output logic                        overflow
);
    localparam int CW = $clog2(NENT + 1);

    logic [CW-1:0] cnt;
    logic          dup;

    // Match detection against every stored pivot.
    for (genvar i = 0; i < NENT; i++) begin : g_cmp
        assign rhit[i] = vld[i] && (prow[i] == flt_row);
        assign chit[i] = vld[i] && (pcol[i] == flt_col);
    end

    // Exact repeat of a stored pivot address.
    assign dup = |(rhit & chit);

    // Pivot update: ignore repeats, flag shared lines, store new failures or overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prow     <= '0;
            pcol     <= '0;
            vld      <= '0;
            esr      <= '0;
            esc      <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else if (accept && flt_vld && !dup) begin
            if ((|rhit) || (|chit)) begin
                esr <= esr | rhit;
                esc <= esc | chit;
            end else if (cnt < CW'(NENT)) begin
                for (int i = 0; i < NENT; i++) begin
                    if (CW'(i) == cnt) begin
                        prow[i] <= flt_row;
                        pcol[i] <= flt_col;
                        vld[i]  <= 1'b1;
                    end
                end
                cnt <= cnt + CW'(1);
            end else begin
                overflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/esp_spare_alloc.sv
// Spare allocator. After end of test it walks the pivot entries one per cycle, twice.
// The first pass serves essential rows and columns, the second covers unflagged pivots,
// rows first. Assumes the pivot file is frozen while the walk runs.
module esp_spare_alloc
    import esp_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int N_SR  = 2,
    parameter int N_SC  = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clr,
    input  logic                                 test_end,
    input  logic [N_SR+N_SC-1:0][ROW_W-1:0]      prow,
    input  logic [N_SR+N_SC-1:0][COL_W-1:0]      pcol,
    input  logic [N_SR+N_SC-1:0]                 vld,
    input  logic [N_SR+N_SC-1:0]                 esr,
    input  logic [N_SR+N_SC-1:0]                 esc,
    input  logic                                 overflow,
    output logic [N_SR-1:0][ROW_W-1:0]           srow,
    output logic [N_SR-1:0]                      srow_use,
    output logic [N_SC-1:0][COL_W-1:0]           scol,
    output logic [N_SC-1:0]                      scol_use,
    output logic                                 collecting,
    output logic                                 done,
    output logic                                 repairable
);
    localparam int NENT = N_SR + N_SC;
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1;
    localparam int RCW  = $clog2(N_SR + 1);
    localparam int CCW  = $clog2(N_SC + 1);

    esp_state_e     st;
    logic [IW-1:0]  idx;
    logic [RCW-1:0] rcnt;
    logic [CCW-1:0] ccnt;
    logic           fail;
    logic           last;
    logic           row_free;
    logic           col_free;

    assign last     = (idx == IW'(NENT - 1));
    assign row_free = (rcnt < RCW'(N_SR));
    assign col_free = (ccnt < CCW'(N_SC));

    // Phase sequencing and slot filling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st       <= ST_COLLECT;
            idx      <= '0;
            rcnt     <= '0;
            ccnt     <= '0;
            fail     <= 1'b0;
            srow     <= '0;
            srow_use <= '0;
            scol     <= '0;
            scol_use <= '0;
        end else begin
            case (st)
                ST_COLLECT: begin
                    if (test_end) begin
                        idx <= '0;
                        if (overflow) begin
                            fail <= 1'b1;
                            st   <= ST_FIN;
                        end else begin
                            st <= ST_ESS;
                        end
                    end
                end
                ST_ESS: begin
                    if (vld[idx] && esr[idx]) begin
                        if (row_free) begin
                            for (int s = 0; s < N_SR; s++) begin
                                if (RCW'(s) == rcnt) begin
                                    srow[s]     <= prow[idx];
                                    srow_use[s] <= 1'b1;
                                end
                            end
                            rcnt <= rcnt + RCW'(1);
                        end else begin
                            fail <= 1'b1;
                        end
                    end
                    if (vld[idx] && esc[idx]) begin
                        if (col_free) begin
                            for (int s = 0; s < N_SC; s++) begin
                                if (CCW'(s) == ccnt) begin
                                    scol[s]     <= pcol[idx];
                                    scol_use[s] <= 1'b1;
                                end
                            end
                            ccnt <= ccnt + CCW'(1);
                        end else begin
                            fail <= 1'b1;
                        end
                    end
                    idx <= last ? '0 : idx + IW'(1);
                    if (last) st <= ST_ORTH;
                end
                ST_ORTH: begin
                    if (vld[idx] && !esr[idx] && !esc[idx]) begin
                        if (row_free) begin
                            for (int s = 0; s < N_SR; s++) begin
                                if (RCW'(s) == rcnt) begin
                                    srow[s]     <= prow[idx];
                                    srow_use[s] <= 1'b1;
                                end
                            end
                            rcnt <= rcnt + RCW'(1);
                        end else if (col_free) begin
                            for (int s = 0; s < N_SC; s++) begin
                                if (CCW'(s) == ccnt) begin
                                    scol[s]     <= pcol[idx];
                                    scol_use[s] <= 1'b1;
                                end
                            end
                            ccnt <= ccnt + CCW'(1);
                        end else begin
                            fail <= 1'b1;
                        end
                    end
                    idx <= last ? '0 : idx + IW'(1);
                    if (last) st <= ST_FIN;
                end
                default: st <= ST_FIN;
            endcase
        end
    end

    // Status decode.
    assign collecting = (st == ST_COLLECT);
    assign done       = (st == ST_FIN);
    assign repairable = done && !fail;
endmodule

// File: rtl/esp_repair_analyzer.sv
// Top level of the bitmap-free redundancy analyzer. Connects the pivot file, which
// collects failures while the allocator is in its collect phase, to the allocator,
// and flattens the slot arrays onto plain ports.
module esp_repair_analyzer #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int N_SR  = 2,
    parameter int N_SC  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    flt_vld_i,
    input  logic [ROW_W-1:0]        flt_row_i,
    input  logic [COL_W-1:0]        flt_col_i,
    input  logic                    test_end_i,
    output logic [N_SR*ROW_W-1:0]   spr_row_o,
    output logic [N_SR-1:0]         spr_row_use_o,
    output logic [N_SC*COL_W-1:0]   spr_col_o,
    output logic [N_SC-1:0]         spr_col_use_o,
    output logic                    done_o,
    output logic                    repairable_o
);
    localparam int NENT = N_SR + N_SC;

    logic [NENT-1:0][ROW_W-1:0] prow;
    logic [NENT-1:0][COL_W-1:0] pcol;
    logic [NENT-1:0]            vld;
    logic [NENT-1:0]            esr;
    logic [NENT-1:0]            esc;
    logic [NENT-1:0]            rhit;
    logic [NENT-1:0]            chit;
    logic                       overflow;
    logic                       collecting;
    logic [N_SR-1:0][ROW_W-1:0] srow;
    logic [N_SC-1:0][COL_W-1:0] scol;

    esp_pivot_file #(.ROW_W(ROW_W), .COL_W(COL_W), .NENT(NENT)) u_pivots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_i),
        .accept   (collecting),
        .flt_vld  (flt_vld_i),
        .flt_row  (flt_row_i),
        .flt_col  (flt_col_i),
        .prow     (prow),
        .pcol     (pcol),
        .vld      (vld),
        .esr      (esr),
        .esc      (esc),
        .rhit     (rhit),
        .chit     (chit),
        .overflow (overflow)
    );

    esp_spare_alloc #(.ROW_W(ROW_W), .COL_W(COL_W), .N_SR(N_SR), .N_SC(N_SC)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_i),
        .test_end   (test_end_i),
        .prow       (prow),
        .pcol       (pcol),
        .vld        (vld),
        .esr        (esr),
        .esc        (esc),
        .overflow   (overflow),
        .srow       (srow),
        .srow_use   (spr_row_use_o),
        .scol       (scol),
        .scol_use   (spr_col_use_o),
        .collecting (collecting),
        .done       (done_o),
        .repairable (repairable_o)
    );

    // Flatten slot arrays onto the ports.
    assign spr_row_o = srow;
    assign spr_col_o = scol;
endmodule

// File: rtl/esp_repair_analyzer_chk.sv
// Property checker for esp_repair_analyzer, attached with bind. It observes the ports
// and the signals passed between the pivot file and the allocator.
module esp_repair_analyzer_chk #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int N_SR  = 2,
    parameter int N_SC  = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      clr_i,
    input logic                      flt_vld_i,
    input logic [N_SR+N_SC-1:0]      vld,
    input logic [N_SR+N_SC-1:0]      esr,
    input logic [N_SR+N_SC-1:0]      esc,
    input logic [N_SR+N_SC-1:0]      rhit,
    input logic [N_SR+N_SC-1:0]      chit,
    input logic                      overflow,
    input logic                      collecting,
    input logic [N_SR*ROW_W-1:0]     spr_row_o,
    input logic [N_SR-1:0]           spr_row_use_o,
    input logic [N_SC*COL_W-1:0]     spr_col_o,
    input logic [N_SC-1:0]           spr_col_use_o,
    input logic                      done_o,
    input logic                      repairable_o
);
    localparam int NENT = N_SR + N_SC;

    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vld == '0) && !done_o && (spr_row_use_o == '0) && (spr_col_use_o == '0));

    a_r2_new_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && flt_vld_i && !clr_i && (rhit == '0) && (chit == '0)
         && ($countones(vld) < NENT))
        |=> ($countones(vld) == $past($countones(vld)) + 1));

    a_r3_flags_on_stored: assert property (@(posedge clk) disable iff (!rst_n)
        ((esr | esc) & ~vld) == '0);

    a_r5_shared_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting && flt_vld_i && !clr_i && ((rhit | chit) != '0))
        |=> $stable(vld));

    a_r7_overflow_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && overflow) |-> !repairable_o);

    a_r9_no_slot_in_collect: assert property (@(posedge clk) disable iff (!rst_n)
        collecting |-> (spr_row_use_o == '0) && (spr_col_use_o == '0));

    a_r10_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> done_o && $stable(repairable_o) && $stable(spr_row_o)
                             && $stable(spr_col_o) && $stable(spr_row_use_o)
                             && $stable(spr_col_use_o));

    a_r11_rep_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        repairable_o |-> done_o);
endmodule

bind esp_repair_analyzer esp_repair_analyzer_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W), .N_SR(N_SR), .N_SC(N_SC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (clr_i),
    .flt_vld_i     (flt_vld_i),
    .vld           (vld),
    .esr           (esr),
    .esc           (esc),
    .rhit          (rhit),
    .chit          (chit),
    .overflow      (overflow),
    .collecting    (collecting),
    .spr_row_o     (spr_row_o),
    .spr_row_use_o (spr_row_use_o),
    .spr_col_o     (spr_col_o),
    .spr_col_use_o (spr_col_use_o),
    .done_o        (done_o),
    .repairable_o  (repairable_o)
);

// File: tb/esp_repair_analyzer_tb.sv
// Directed bench for esp_repair_analyzer with 2 spare rows, 2 spare columns and
// 4-bit addresses. Inputs change and outputs are sampled on the falling edge.
module esp_repair_analyzer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       flt_vld_i = 1'b0;
    logic [3:0] flt_row_i = '0;
    logic [3:0] flt_col_i = '0;
    logic       test_end_i = 1'b0;
    logic [7:0] spr_row_o;
    logic [1:0] spr_row_use_o;
    logic [7:0] spr_col_o;
    logic [1:0] spr_col_use_o;
    logic       done_o;
    logic       repairable_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5ns clk = ~clk;

    esp_repair_analyzer #(.ROW_W(4), .COL_W(4), .N_SR(2), .N_SC(2)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr_i),
        .flt_vld_i     (flt_vld_i),
        .flt_row_i     (flt_row_i),
        .flt_col_i     (flt_col_i),
        .test_end_i    (test_end_i),
        .spr_row_o     (spr_row_o),
        .spr_row_use_o (spr_row_use_o),
        .spr_col_o     (spr_col_o),
        .spr_col_use_o (spr_col_use_o),
        .done_o        (done_o),
        .repairable_o  (repairable_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk); clr_i = 1'b1;
        @(negedge clk); clr_i = 1'b0;
    endtask

    task automatic send(input int r, input int c);
        @(negedge clk);
        flt_vld_i = 1'b1; flt_row_i = 4'(r); flt_col_i = 4'(c);
        @(negedge clk);
        flt_vld_i = 1'b0;
    endtask

    task automatic finish_test(input string req);
        @(negedge clk); test_end_i = 1'b1;
        @(negedge clk); test_end_i = 1'b0;
        for (int k = 0; k < 40 && !done_o; k++) @(negedge clk);
        chk(req, "done", int'(done_o), 1);
    endtask

    task automatic expect_res(input string req, input int rep, input int rows, input int ruse,
                              input int cols, input int cuse);
        chk(req, "repairable", int'(repairable_o), rep);
        chk(req, "spare rows", int'(spr_row_o), rows);
        chk(req, "row use", int'(spr_row_use_o), ruse);
        chk(req, "spare cols", int'(spr_col_o), cols);
        chk(req, "col use", int'(spr_col_use_o), cuse);
    endtask

    // R1: reset state and state after clear.
    task automatic t_reset();
        chk("R1", "done after reset", int'(done_o), 0);
        chk("R1", "repairable after reset", int'(repairable_o), 0);
        chk("R1", "row use after reset", int'(spr_row_use_o), 0);
        chk("R1", "col use after reset", int'(spr_col_use_o), 0);
    endtask

    // R2, R6, R9: orthogonal failures with repeats, rows first then columns.
    task automatic t_orthogonal();
        restart();
        send(1, 1); send(2, 2); send(2, 2); send(2, 2); send(3, 3); send(1, 1); send(4, 4);
        finish_test("R2");
        expect_res("R2 R6 R9", 1, 'h21, 'b11, 'h43, 'b11);
    endtask

    // R3, R4, R9: shared row and shared column served before orthogonal pivots.
    task automatic t_mixed();
        restart();
        send(1, 0); send(1, 6); send(2, 4); send(3, 4); send(5, 1); send(7, 3);
        finish_test("R3");
        expect_res("R3 R4 R9", 1, 'h51, 'b11, 'h34, 'b11);
    endtask

    // R5: a failure on a stored row and a stored column takes no entry.
    task automatic t_cross();
        restart();
        send(1, 2); send(3, 4); send(1, 4); send(5, 5); send(6, 6);
        finish_test("R5");
        expect_res("R5", 1, 'h51, 'b11, 'h64, 'b11);
    endtask

    // R7: a fifth orthogonal failure overflows the pivot list.
    task automatic t_overflow();
        restart();
        send(1, 1); send(2, 2); send(3, 3); send(4, 4); send(5, 5);
        finish_test("R7");
        chk("R7", "repairable", int'(repairable_o), 0);
    endtask

    // R8: too many essential rows, then too many essential columns.
    task automatic t_essential_excess();
        restart();
        send(1, 1); send(1, 2); send(2, 3); send(2, 4); send(3, 5); send(3, 6);
        finish_test("R8");
        chk("R8", "repairable with 3 essential rows", int'(repairable_o), 0);
        restart();
        send(1, 1); send(2, 1); send(3, 2); send(4, 2); send(5, 3); send(6, 3);
        finish_test("R8");
        chk("R8", "repairable with 3 essential cols", int'(repairable_o), 0);
    endtask

    // R10, R1: results hold while failures arrive after done, then clear empties.
    task automatic t_freeze();
        restart();
        send(9, 8); send(7, 6);
        finish_test("R10");
        expect_res("R10", 1, 'h79, 'b11, 'h00, 'b00);
        send(9, 1); send(10, 10); send(11, 11);
        repeat (5) @(negedge clk);
        chk("R10", "done held", int'(done_o), 1);
        expect_res("R10", 1, 'h79, 'b11, 'h00, 'b00);
        restart();
        chk("R1", "done after clear", int'(done_o), 0);
        chk("R1", "row use after clear", int'(spr_row_use_o), 0);
        chk("R1", "repairable after clear", int'(repairable_o), 0);
    endtask

    // R11: empty session, and repairable stays low before done.
    task automatic t_empty();
        restart();
        chk("R11", "repairable before done", int'(repairable_o), 0);
        finish_test("R11");
        expect_res("R11", 1, 'h00, 'b00, 'h00, 'b00);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_orthogonal();
        t_mixed();
        t_cross();
        t_overflow();
        t_essential_excess();
        t_freeze();
        t_empty();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule